// File: doc/BRIEF.md
# Byte-wide strobed register bus master

This block lets on-chip logic reach 16-bit registers in an external peripheral over a narrow parallel bus. The peripheral has an 8-bit register address space. The user side takes a one-cycle start pulse together with a read/write flag, an address and, for a write, a 16-bit value. It answers with a one-cycle done pulse and, for a read, a 16-bit result. A busy flag covers the whole transaction.

On the bus side the master sets the transfer direction and then runs three strobed byte phases. The first phase carries the address with the address-latch line high. The other two carry the register value, upper byte first. The data lines have a separate output and input and an output-enable, so a pad ring or a bench can build the bidirectional pin. Chip-select is then raised and the ready line is checked through a synchroniser. A read that finds ready high repeats both data bytes in full. A write that finds ready high pulses chip-select low and high until ready drops.

Every bus step lasts a parameterised number of system clocks (`STEP_CLKS`, default 2). The ready check waits that long plus the synchroniser depth (`SYNC_STAGES`, default 2).

Top module: `regbus_master`

## Requirements
- R1: Out of reset and whenever the block is idle, the outputs have these levels: chip-select high, strobe low, address-latch low, data lines driven (output-enable high) at 8'hFF, busy low, done low. Directly after reset the direction line is high.
- R2: The direction line goes low for a read and high for a write `STEP_CLKS` cycles before the address phase begins. It then holds that level for the whole transaction.
- R3: Each byte phase lasts three steps. In the first step chip-select, strobe, address-latch and the data lines are all low. In the second step the byte is driven. In the third step strobe is high. In the address phase, address-latch is high together with the address during the second and third steps. Address-latch is high in no other phase, and strobe is high only while chip-select is low.
- R4: A write moves its value in two data phases with address-latch low: bits 15:8 first, then bits 7:0. Bit i of each byte appears on data line i.
- R5: A read releases the data lines (output-enable low) from the first data phase until the transaction ends. It samples the data input on the last clock of each strobe-high step. The first byte sampled becomes result bits 15:8 and the second becomes bits 7:0.
- R6: After the second data byte, chip-select goes high, and ready is judged `STEP_CLKS + SYNC_STAGES` cycles later. On a read with ready high, both data phases and the chip-select rise are repeated without a new address phase. The result comes from the last attempt.
- R7: On a write with ready high, chip-select is driven low for one step and then high again, and ready is checked again each time. The write ends on the first check that finds ready low.
- R8: Done is high for exactly one cycle, and busy is low on the following cycle. The read result stays unchanged while the block is idle.
- R9: A start pulse that arrives while busy is high has no effect. It starts no transaction and changes neither the address nor the data of the transaction in progress.
- R10: A transaction with no ready retries shows done `11*STEP_CLKS + 3` cycles after the start is sampled. Each write chip-select pulse adds `2*STEP_CLKS + 2` cycles. Each read retry adds `7*STEP_CLKS + 2` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request to begin a transaction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Peripheral register address |
| req_wdata | input | 16 | Value to write |
| rsp_rdata | output | 16 | Result of the last completed read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_busy | output | 1 | Transaction in progress |
| bus_dout | output | 8 | Data lines, outgoing value |
| bus_doe | output | 1 | Data line output-enable |
| bus_din | input | 8 | Data lines, incoming value |
| bus_cs | output | 1 | Chip-select, active low |
| bus_dir | output | 1 | Transfer direction, high for write |
| bus_stb | output | 1 | Byte strobe |
| bus_ale | output | 1 | Address-latch enable |
| bus_rdy | input | 1 | Peripheral ready, high means not finished |

## Verification
The assertions check the pin-level rules on every cycle:
- the idle levels;
- strobe only under a low chip-select;
- address-latch only with driven data;
- data released during read strobes;
- a steady direction during a transaction;
- a single-cycle done followed by idle;
- a steady read result while idle.

Other behaviour only the bench scenarios can show. These are byte order, retry counts and latency, that the result of the final read attempt is the one returned, and that a start during busy is dropped. The bench shows them by modelling the peripheral, which corrupts the data on attempts that will report ready high and holds ready high for a chosen number of chip-select rises.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_RST,
        ST_SET,
        ST_STB,
        ST_CSH,
        ST_CSL,
        ST_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_HI,
        PH_LO
    } phase_e;

    typedef struct packed {
        logic        write;
        logic [7:0]  addr;
        logic [15:0] wdata;
    } req_t;

    typedef struct packed {
        logic [7:0] dout;
        logic       oe;
        logic       cs;
        logic       dir;
        logic       stb;
        logic       ale;
    } pins_t;

    localparam logic [7:0] DATA_IDLE = 8'hFF;

    function automatic logic [7:0] phase_byte(input req_t r, input phase_e p);
        case (p)
            PH_ADDR: phase_byte = r.addr;
            PH_HI:   phase_byte = r.wdata[15:8];
            default: phase_byte = r.wdata[7:0];
        endcase
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        next_phase = (p == PH_ADDR) ? PH_HI : PH_LO;
    endfunction

endpackage

// File: rtl/regbus_sync.sv
module regbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[g] <= 1'b0;
            else if (g == 0)
                chain[g] <= d;
            else
                chain[g] <= chain[(g == 0) ? 0 : g - 1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/regbus_timer.sv
module regbus_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/regbus_seq.sv
module regbus_seq
    import regbus_pkg::*;
#(
    parameter int STEP_CLKS   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int TW          = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  req_t          req,
    input  logic [7:0]    din,
    input  logic          rdy_s,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output pins_t         pins,
    output logic [15:0]   rdata,
    output logic          done,
    output logic          busy
);
    localparam logic [TW-1:0] STEP_LAST  = TW'(STEP_CLKS - 1);
    localparam logic [TW-1:0] CHECK_LAST = TW'(STEP_CLKS + SYNC_STAGES - 1);

    seq_state_e  st, st_n;
    phase_e      ph, ph_n;
    req_t        rq;
    logic [15:0] shadow;
    logic [15:0] rdata_q;
    logic        drive_data;

    always_comb begin
        st_n = st;
        ph_n = ph;
        case (st)
            ST_IDLE: if (start) st_n = ST_DIR;
            ST_DIR: if (tmr_expired) begin
                st_n = ST_RST;
                ph_n = PH_ADDR;
            end
            ST_RST: if (tmr_expired) st_n = ST_SET;
            ST_SET: if (tmr_expired) st_n = ST_STB;
            ST_STB: if (tmr_expired) begin
                if (ph == PH_LO) begin
                    st_n = ST_CSH;
                end else begin
                    st_n = ST_RST;
                    ph_n = next_phase(ph);
                end
            end
            ST_CSH: if (tmr_expired) begin
                if (!rdy_s) begin
                    st_n = ST_FIN;
                end else if (rq.write) begin
                    st_n = ST_CSL;
                end else begin
                    st_n = ST_RST;
                    ph_n = PH_HI;
                end
            end
            ST_CSL: if (tmr_expired) st_n = ST_CSH;
            ST_FIN: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    assign tmr_load = (st_n != st);
    assign tmr_val  = (st_n == ST_CSH) ? CHECK_LAST : STEP_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ph      <= PH_ADDR;
            rq      <= '{write: 1'b1, addr: '0, wdata: '0};
            shadow  <= '0;
            rdata_q <= '0;
        end else begin
            st <= st_n;
            ph <= ph_n;
            if (st == ST_IDLE && start)
                rq <= req;
            if (st == ST_STB && tmr_expired && !rq.write && ph != PH_ADDR) begin
                if (ph == PH_HI)
                    shadow[15:8] <= din;
                else
                    shadow[7:0] <= din;
            end
            if (st == ST_CSH && tmr_expired && !rdy_s && !rq.write)
                rdata_q <= shadow;
        end
    end

    assign drive_data = rq.write || (ph == PH_ADDR);

    always_comb begin
        pins      = '{dout: DATA_IDLE, oe: 1'b1, cs: 1'b1, dir: rq.write,
                      stb: 1'b0, ale: 1'b0};
        case (st)
            ST_RST: begin
                pins.dout = '0;
                pins.oe   = drive_data;
                pins.cs   = 1'b0;
            end
            ST_SET, ST_STB: begin
                pins.dout = phase_byte(rq, ph);
                pins.oe   = drive_data;
                pins.cs   = 1'b0;
                pins.ale  = (ph == PH_ADDR);
                pins.stb  = (st == ST_STB);
            end
            ST_CSH: pins.oe = rq.write;
            ST_CSL: begin
                pins.oe = rq.write;
                pins.cs = 1'b0;
            end
            default: ;
        endcase
    end

    assign rdata = rdata_q;
    assign done  = (st == ST_FIN);
    assign busy  = (st != ST_IDLE);
endmodule

// File: rtl/regbus_master.sv
module regbus_master
    import regbus_pkg::*;
#(
    parameter int STEP_CLKS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_start,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic [15:0] rsp_rdata,
    output logic        rsp_done,
    output logic        rsp_busy,
    output logic [7:0]  bus_dout,
    output logic        bus_doe,
    input  logic [7:0]  bus_din,
    output logic        bus_cs,
    output logic        bus_dir,
    output logic        bus_stb,
    output logic        bus_ale,
    input  logic        bus_rdy
);
    localparam int TW = $clog2(STEP_CLKS + SYNC_STAGES + 1);

    logic          rdy_s;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    pins_t         pins;
    req_t          req;

    assign req = '{write: req_write, addr: req_addr, wdata: req_wdata};

    regbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_rdy),
        .q   (rdy_s)
    );

    regbus_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    regbus_seq #(
        .STEP_CLKS   (STEP_CLKS),
        .SYNC_STAGES (SYNC_STAGES),
        .TW          (TW)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (req_start),
        .req         (req),
        .din         (bus_din),
        .rdy_s       (rdy_s),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .pins        (pins),
        .rdata       (rsp_rdata),
        .done        (rsp_done),
        .busy        (rsp_busy)
    );

    assign bus_dout = pins.dout;
    assign bus_doe  = pins.oe;
    assign bus_cs   = pins.cs;
    assign bus_dir  = pins.dir;
    assign bus_stb  = pins.stb;
    assign bus_ale  = pins.ale;
endmodule

// File: rtl/regbus_checker.sv
module regbus_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] rsp_rdata,
    input logic        rsp_done,
    input logic        rsp_busy,
    input logic [7:0]  bus_dout,
    input logic        bus_doe,
    input logic        bus_cs,
    input logic        bus_dir,
    input logic        bus_stb,
    input logic        bus_ale
);
    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        !rsp_busy |-> (bus_cs && !bus_stb && !bus_ale && bus_doe && bus_dout == 8'hFF)); // R1

    AST_DIR_STEADY: assert property (@(posedge clk) disable iff (rst)
        (rsp_busy && $past(rsp_busy)) |-> $stable(bus_dir)); // R2

    AST_STB_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
        bus_stb |-> !bus_cs); // R3

    AST_ALE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> bus_doe); // R3

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (rsp_busy && bus_dir) |-> bus_doe); // R4

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_ale && !bus_dir) |-> !bus_doe); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && !rsp_busy)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rsp_busy && !$past(rsp_busy)) |-> $stable(rsp_rdata)); // R8
endmodule

bind regbus_master regbus_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rsp_rdata (rsp_rdata),
    .rsp_done  (rsp_done),
    .rsp_busy  (rsp_busy),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .bus_cs    (bus_cs),
    .bus_dir   (bus_dir),
    .bus_stb   (bus_stb),
    .bus_ale   (bus_ale)
);

// File: tb/tb_regbus_master.sv
module tb_regbus_master;
    localparam int STEP = 2;
    localparam int BASE_LAT = 11 * STEP + 3;
    localparam int WR_EXTRA = 2 * STEP + 2;
    localparam int RD_EXTRA = 7 * STEP + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_done, rsp_busy;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic [7:0]  bus_din = '0;
    logic        bus_cs, bus_dir, bus_stb, bus_ale;
    logic        bus_rdy = 1'b0;

    always #10 clk = ~clk;

    regbus_master #(.STEP_CLKS(STEP), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .rsp_busy(rsp_busy), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_cs(bus_cs), .bus_dir(bus_dir),
        .bus_stb(bus_stb), .bus_ale(bus_ale), .bus_rdy(bus_rdy)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Peripheral model
    logic [15:0] mem [256];
    logic [7:0]  per_addr = '0;
    logic [7:0]  wr_hi = '0;
    int          byte_idx = 0;
    int          pend = 0;
    int          n_stb = 0, n_ale = 0, n_rise = 0;
    bit          rel_err = 0, dir_err = 0;
    bit          cur_dir = 1'b1;
    logic        p_stb = 0, p_cs = 1, p_busy = 0;

    function automatic logic [15:0] init_val(input int a);
        return {8'(a) ^ 8'hA5, ~8'(a)};
    endfunction

    initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);

    always @(negedge clk) begin
        if (rsp_busy && !p_busy) begin
            n_stb = 0; n_ale = 0; n_rise = 0; rel_err = 0; dir_err = 0;
        end
        if (bus_stb && !p_stb) begin
            n_stb++;
            if (bus_dir != cur_dir) dir_err = 1;
            if (bus_ale) begin
                n_ale++;
                per_addr = bus_dout;
                byte_idx = 0;
            end else if (bus_dir) begin
                if (byte_idx == 0) wr_hi = bus_dout;
                else mem[per_addr] = {wr_hi, bus_dout};
                byte_idx++;
            end else begin
                if (bus_doe) rel_err = 1;
                if (pend > 0)
                    bus_din = (byte_idx == 0) ? ~mem[per_addr][15:8] : ~mem[per_addr][7:0];
                else
                    bus_din = (byte_idx == 0) ? mem[per_addr][15:8] : mem[per_addr][7:0];
                byte_idx++;
            end
        end
        if (bus_cs && !p_cs && rsp_busy) begin
            n_rise++;
            byte_idx = 0;
            if (pend > 0) begin
                pend--;
                bus_rdy = 1'b1;
            end else begin
                bus_rdy = 1'b0;
            end
        end
        p_stb = bus_stb; p_cs = bus_cs; p_busy = rsp_busy;
    end

    // Scoreboard
    typedef struct {
        bit          wr;
        logic [7:0]  addr;
        logic [15:0] data;
        int          strobes;
        int          rises;
    } exp_t;
    exp_t sbq[$];

    always @(negedge clk) begin
        if (rsp_done && !rst) begin
            if (sbq.size() == 0) begin
                check(0, "R9", "unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(per_addr == e.addr, "R3", "address on bus", per_addr, e.addr);
                check(n_ale == 1, "R3", "address-latch strobes", n_ale, 1);
                check(!dir_err, e.wr ? "R2 write" : "R2 read", "direction at strobes", dir_err, 0);
                check(n_stb == e.strobes, e.wr ? "R7" : "R6", "strobe count", n_stb, e.strobes);
                check(n_rise == e.rises, e.wr ? "R7" : "R6", "chip-select rises", n_rise, e.rises);
                if (e.wr) begin
                    check(mem[e.addr] == e.data, "R4", "written value", mem[e.addr], e.data);
                end else begin
                    check(!rel_err, "R5", "data released during read", rel_err, 0);
                    check(rsp_rdata == e.data, "R5 R6", "read result", rsp_rdata, e.data);
                end
            end
        end
    end

    // Driver
    task automatic run_txn(input bit wr, input logic [7:0] addr, input logic [15:0] wdata,
                           input int npend, input bit poke_busy);
        exp_t e;
        int cyc;
        int lat;
        e.wr = wr;
        e.addr = addr;
        e.data = wr ? wdata : ((npend >= 0) ? mem[addr] : 16'h0);
        e.strobes = wr ? 3 : 1 + 2 * (npend + 1);
        e.rises = npend + 1;
        lat = BASE_LAT + npend * (wr ? WR_EXTRA : RD_EXTRA);
        sbq.push_back(e);
        pend = npend;
        cur_dir = wr;
        @(negedge clk);
        req_write = wr; req_addr = addr; req_wdata = wdata; req_start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            req_start = 1'b0;
            if (poke_busy && cyc == 6) begin
                req_start = 1'b1; req_write = ~wr; req_addr = 8'h44; req_wdata = 16'hDEAD;
            end
        end while (!rsp_done && cyc < 2000);
        req_start = 1'b0;
        check(cyc == lat, "R10", "cycles to done", cyc, lat);
        @(negedge clk);
        check(!rsp_done, "R8", "done width", rsp_done, 0);
        check(!rsp_busy, "R8", "busy after done", rsp_busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(bus_cs == 1'b1, "R1", "cs idle", bus_cs, 1);
        check(!bus_stb && !bus_ale, "R1", "stb/ale idle", {bus_stb, bus_ale}, 0);
        check(bus_doe && bus_dout == 8'hFF, "R1", "data idle", {bus_doe, bus_dout}, 9'h1FF);
        check(!rsp_busy && !rsp_done, "R1", "busy/done idle", {rsp_busy, rsp_done}, 0);
        check(bus_dir == 1'b1, "R1", "dir after reset", bus_dir, 1);

        run_txn(1'b1, 8'h12, 16'hBEEF, 0, 1'b0);      // R3 R4 R10
        run_txn(1'b0, 8'h12, 16'h0000, 0, 1'b0);      // R5
        run_txn(1'b0, 8'h80, 16'h0000, 2, 1'b0);      // R6 read retries
        run_txn(1'b1, 8'hFF, 16'h00A5, 3, 1'b0);      // R7 write cs pulses
        run_txn(1'b0, 8'hFF, 16'h0000, 1, 1'b0);      // R6 R2 read
        check(bus_dir == 1'b0, "R2", "dir held low after read", bus_dir, 0);

        // R8 result holds while idle
        held = rsp_rdata;
        repeat (10) @(negedge clk);
        check(rsp_rdata == held && held == 16'h00A5, "R8", "result held", rsp_rdata, 16'h00A5);

        // R9 start while busy ignored
        run_txn(1'b1, 8'h33, 16'h1234, 0, 1'b1);
        repeat (4) begin
            @(negedge clk);
            check(!rsp_busy, "R9", "no second transaction", rsp_busy, 0);
        end
        check(mem[8'h44] == init_val(8'h44), "R9", "untouched register", mem[8'h44], init_val(8'h44));
        check(sbq.size() == 0, "R9", "scoreboard drained", sbq.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule